// File: doc/BRIEF.md
# Operate-Instruction Execute Unit

This block carries out the three register-to-register operations of a small 16-bit load/store instruction set: two's-complement addition, bitwise AND and bitwise complement. It holds eight 16-bit general-purpose registers and a three-flag condition code. An instruction word arrives with a one-cycle valid strobe. The unit decodes it, reads one or two source registers, computes the result, writes it back and updates the flags, all in a single cycle. For ADD and AND, one mode bit picks the second operand: either a register or a sign-extended 5-bit constant carried in the instruction.

A side port reads any register combinationally, so a surrounding pipeline or a testbench can observe the register file. Any instruction word whose opcode is not one of the three handled here is dropped, and no state changes. Fetch, memory operations, branches and traps are handled elsewhere.

Top module: `opx_exec_unit`

## Requirements
- R1: Opcode 4'b0001 in bits [15:12] is ADD. The destination register number is in bits [11:9] and the first source register number is in bits [8:6]. The sum wraps modulo 2^16 and no overflow indication exists.
- R2: With bit 5 equal to 0, the second ADD/AND operand is the register named by bits [2:0]. The values of bits [4:3] have no effect on the result.
- R3: With bit 5 equal to 1, the second ADD/AND operand is bits [4:0], sign-extended from bit 4 to 16 bits.
- R4: Opcode 4'b0101 is AND and writes the bitwise AND of its two operands to the destination.
- R5: Opcode 4'b1001 is NOT and writes the bitwise complement of the first source register to the destination. The values of bits [5:0] have no effect.
- R6: After every register write, exactly one of flag_n, flag_z and flag_p is 1. flag_n is set when bit 15 of the written value is 1, flag_z when the value is zero, and flag_p otherwise.
- R7: The register write and the flag update both take effect on the rising clock edge that closes the cycle in which instr_vld is high. An instruction may be accepted every cycle, and each one sees the results of the one before it.
- R8: When instr_vld is low, or when the opcode is any value other than 0001, 0101 or 1001, no register and no flag changes.
- R9: A low level on rst_n at once clears all eight registers to zero and sets the flags to N=0, Z=1, P=0. Release of the reset is synchronised over two rising clock edges, and instructions presented before release completes are dropped.
- R10: dbg_data shows, without a clock delay, the current content of the register numbered by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word |
| dbg_sel | input | 3 | Register number for the debug read |
| dbg_data | output | 16 | Content of the selected register |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was positive |

## Verification
The bench builds the unit with its default parameters: a 16-bit word and eight registers. These are the widths the instruction fields address, so every register number, the full immediate range from -16 to +15, and wrap-around at 2^16 all lie within reach. The bench uses the value FFFF to drive both the carry out of bit 15 and a zero result, and it uses a destination that is also a source to exercise the read-then-write path. It further drives reserved-bit patterns, four foreign opcodes, a cycle with the strobe held low, back-to-back strobes, and a reset asserted in the middle of a run.

// File: rtl/opx_pkg.sv
package opx_pkg;

  localparam int WORD_W  = 16;
  localparam int REG_CNT = 8;
  localparam int RA_W    = $clog2(REG_CNT);
  localparam int IMM_W   = 5;
  localparam int OPC_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic              legal;
    alu_op_e           op;
    logic [RA_W-1:0]   rd;
    logic [RA_W-1:0]   rs1;
    logic [RA_W-1:0]   rs2;
    logic              use_imm;
    logic [WORD_W-1:0] imm;
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] raw);
    return {{(WORD_W-IMM_W){raw[IMM_W-1]}}, raw};
  endfunction

  function automatic cc_t classify(input logic [WORD_W-1:0] v);
    cc_t c;
    c.n = v[WORD_W-1];
    c.z = (v == '0);
    c.p = !v[WORD_W-1] && (v != '0);
    return c;
  endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output dec_t              dec_o
);

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc           = instr_i[15:12];
    dec_o         = '0;
    dec_o.rd      = instr_i[11:9];
    dec_o.rs1     = instr_i[8:6];
    dec_o.rs2     = instr_i[2:0];
    dec_o.use_imm = instr_i[5];
    dec_o.imm     = sext_imm(instr_i[IMM_W-1:0]);
    dec_o.op      = ALU_ADD;
    unique case (opc)
      OPC_ADD: begin
        dec_o.legal = 1'b1;
        dec_o.op    = ALU_ADD;
      end
      OPC_AND: begin
        dec_o.legal = 1'b1;
        dec_o.op    = ALU_AND;
      end
      OPC_NOT: begin
        dec_o.legal   = 1'b1;
        dec_o.op      = ALU_NOT;
        dec_o.use_imm = 1'b0;
      end
      default: begin
        dec_o.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/opx_regfile.sv
module opx_regfile
  import opx_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int N  = REG_CNT,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic [AW-1:0] ra3_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  output logic [W-1:0]  rd3_o
);

  logic [W-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic         en;
    logic [W-1:0] nxt;

    always_comb begin
      en  = we_i && (wa_i == AW'(g));
      nxt = wd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (en) begin
        mem_q[g] <= nxt;
      end
    end
  end

  always_comb begin
    rd1_o = mem_q[ra1_i];
    rd2_o = mem_q[ra2_i];
    rd3_o = mem_q[ra3_i];
  end

endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  alu_op_e       op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [W-1:0]  y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_NOT: y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end

endmodule

// File: rtl/opx_ccreg.sv
module opx_ccreg
  import opx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_i,
  input  logic [W-1:0] val_i,
  output cc_t          cc_o
);

  cc_t cc_q;
  cc_t cc_d;

  always_comb begin
    cc_d = cc_q;
    if (upd_i) begin
      cc_d = classify(val_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    end else begin
      cc_q <= cc_d;
    end
  end

  assign cc_o = cc_q;

endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
  import opx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_vld,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [RA_W-1:0]   dbg_sel,
  output logic [WORD_W-1:0] dbg_data,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);

  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  dec_t              dec;
  logic [WORD_W-1:0] rs1_data;
  logic [WORD_W-1:0] rs2_data;
  logic [WORD_W-1:0] opb;
  logic [WORD_W-1:0] wr_data;
  logic              wr_en;
  cc_t               cc;

  opx_decode u_dec (
    .instr_i (instr_word),
    .dec_o   (dec)
  );

  always_comb begin
    opb   = dec.use_imm ? dec.imm : rs2_data;
    wr_en = instr_vld && rst_q && dec.legal;
  end

  opx_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (wr_en),
    .wa_i  (dec.rd),
    .wd_i  (wr_data),
    .ra1_i (dec.rs1),
    .ra2_i (dec.rs2),
    .ra3_i (dbg_sel),
    .rd1_o (rs1_data),
    .rd2_o (rs2_data),
    .rd3_o (dbg_data)
  );

  opx_alu #(.W(WORD_W)) u_alu (
    .op_i (dec.op),
    .a_i  (rs1_data),
    .b_i  (opb),
    .y_o  (wr_data)
  );

  opx_ccreg #(.W(WORD_W)) u_cc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_i (wr_en),
    .val_i (wr_data),
    .cc_o  (cc)
  );

  assign flag_n = cc.n;
  assign flag_z = cc.z;
  assign flag_p = cc.p;

endmodule

// File: rtl/opx_exec_chk.sv
module opx_exec_chk
  import opx_pkg::*;
(
  input logic              clk,
  input logic              rst_ok,
  input logic              instr_vld,
  input logic [WORD_W-1:0] instr_word,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rs1_data,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_p
);

  logic known_op;
  assign known_op = (instr_word[15:12] == OPC_ADD) ||
                    (instr_word[15:12] == OPC_AND) ||
                    (instr_word[15:12] == OPC_NOT);

  // R6
  onehot_flags_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones({flag_n, flag_z, flag_p}) == 1);

  // R6
  flag_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> (flag_z == ($past(wr_data) == '0)) && (flag_n == $past(wr_data[WORD_W-1])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!instr_vld || !known_op) |=> $stable({flag_n, flag_z, flag_p}));

  // R8
  no_write_foreign_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !known_op |-> !wr_en);

  // R5
  not_result_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && instr_word[15:12] == OPC_NOT) |-> wr_data == ~rs1_data);

  // R3
  add_imm_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && instr_word[15:12] == OPC_ADD && instr_word[5])
      |-> wr_data == rs1_data + {{(WORD_W-IMM_W){instr_word[4]}}, instr_word[4:0]});

endmodule

bind opx_exec_unit opx_exec_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_q),
  .instr_vld  (instr_vld),
  .instr_word (instr_word),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rs1_data   (rs1_data),
  .flag_n     (flag_n),
  .flag_z     (flag_z),
  .flag_p     (flag_p)
);

// File: tb/opx_exec_unit_tb.sv
module opx_exec_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        instr_vld;
  logic [15:0] instr_word;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_data;
  logic        flag_n, flag_z, flag_p;

  int n_chk;
  int n_bad;

  opx_exec_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_vld  (instr_vld),
    .instr_word (instr_word),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_p     (flag_p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] instr;
    logic [2:0]  reg_no;
    logic [15:0] val;
    logic [2:0]  nzp;
  } vec_t;

  localparam int NV = 18;
  // flags encoded {N,Z,P}
  localparam vec_t VEC [NV] = '{
    '{16'h1225, 3'd1, 16'h0005, 3'b001}, // R1 R3 ADD R1,R0,#5
    '{16'h143F, 3'd2, 16'hFFFF, 3'b100}, // R3 imm -1
    '{16'h1642, 3'd3, 16'h0004, 3'b001}, // R2 R1 wrap 5+FFFF
    '{16'h58AF, 3'd4, 16'h000F, 3'b001}, // R4 AND imm 15
    '{16'h9B3F, 3'd5, 16'hFFF0, 3'b100}, // R5 NOT
    '{16'h5D44, 3'd6, 16'h0000, 3'b010}, // R4 R2 AND reg -> zero
    '{16'h1EA1, 3'd7, 16'h0000, 3'b010}, // R1 FFFF+1 wraps to zero
    '{16'h1270, 3'd1, 16'hFFF5, 3'b100}, // R3 imm -16
    '{16'h1041, 3'd0, 16'hFFEA, 3'b100}, // R1 R2 same reg twice
    '{16'h903F, 3'd0, 16'h0015, 3'b001}, // R5 dst == src
    '{16'h56FF, 3'd3, 16'h0004, 3'b001}, // R4 AND imm all ones
    '{16'h1818, 3'd4, 16'h002A, 3'b001}, // R2 bits [4:3]=11 ignored
    '{16'h9D00, 3'd6, 16'hFFD5, 3'b100}, // R5 bits [5:0]=0 ignored
    '{16'h2201, 3'd1, 16'hFFF5, 3'b100}, // R8 opcode 0010 dropped
    '{16'hF025, 3'd0, 16'h0015, 3'b100}, // R8 opcode 1111 dropped
    '{16'h0E05, 3'd7, 16'h0000, 3'b100}, // R8 opcode 0000 dropped
    '{16'hC1C0, 3'd6, 16'hFFD5, 3'b100}, // R8 opcode 1100 dropped
    '{16'h1A2F, 3'd5, 16'h0024, 3'b001}  // R6 flags move again
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [2:0] r,
                      input logic [15:0] v, input logic [2:0] f);
    dbg_sel = r;
    #1;
    check(req, dbg_data, v);
    check(req, {13'd0, flag_n, flag_z, flag_p}, {13'd0, f});
  endtask

  task automatic issue(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr_word = w;
    instr_vld  = v;
    @(negedge clk);
    instr_vld  = 1'b0;
  endtask

  bit done;

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    instr_vld  = 1'b0;
    instr_word = 16'h0;
    dbg_sel    = 3'd0;
    repeat (3) @(negedge clk);

    // R9 reset state: all registers zero, flags Z
    for (int r = 0; r < 8; r++) peek("R9", 3'(r), 16'h0000, 3'b010);

    // R9 instruction during synchronised release is dropped
    @(negedge clk);
    rst_n      = 1'b1;
    instr_word = 16'h1225;
    instr_vld  = 1'b1;
    @(negedge clk);
    instr_vld  = 1'b0;
    peek("R9", 3'd1, 16'h0000, 3'b010);
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].instr, 1'b1);
      peek($sformatf("vec%0d", i), VEC[i].reg_no, VEC[i].val, VEC[i].nzp);
    end

    // R8 strobe low: ADD R5,R5,#1 not applied
    issue(16'h1B61, 1'b0);
    peek("R8", 3'd5, 16'h0024, 3'b001);

    // R7 back-to-back strobes, second sees first
    @(negedge clk);
    instr_word = 16'h1B61;
    instr_vld  = 1'b1;
    @(negedge clk);
    peek("R7", 3'd5, 16'h0025, 3'b001);
    @(negedge clk);
    instr_vld = 1'b0;
    peek("R7", 3'd5, 16'h0026, 3'b001);

    // R10 debug read follows selector without clock
    dbg_sel = 3'd6;
    #1;
    check("R10", dbg_data, 16'hFFD5);
    dbg_sel = 3'd0;
    #1;
    check("R10", dbg_data, 16'h0015);

    // R9 asynchronous reset mid-run
    #2;
    rst_n = 1'b0;
    #1;
    peek("R9", 3'd5, 16'h0000, 3'b010);
    peek("R9", 3'd6, 16'h0000, 3'b010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule